// File: doc/BRIEF.md
# Two-Output Selector Serial Control Port

This block is the two-wire serial slave behind a source selector with two outputs. It watches already-synchronised SCL and SDA levels and answers its own 7-bit address. A strap input picks one of two addresses. A write transfer carries exactly two data bytes: the first sets the control word for output one and the second sets the control word for output two. Both words appear as registered parallel outputs. A read transfer returns one status byte. That byte carries a flag that is set by reset and cleared as soon as a read begins, and it also carries the decoded levels of two three-level strap pins.

The block drives the bus only through an open-drain pull-down enable, `sda_oe_o`. The outer logic ties that enable to the SDA pad. The system clock must run much faster than SCL, so that every SCL edge and every start or stop condition is seen as a level change between two clock samples. The block changes SDA one to two clock cycles after it sees SCL fall. This keeps the data hold time far above the bus minimum.

Top module: `avsel_i2c_slave`

## Requirements
- R1: The device address is 7'b1001000 when `addr_sel_i` is 0 and 7'b1001001 when it is 1, taken from the first seven bits after a start (MSB first; the eighth bit is 0 for write, 1 for read). A matching address is acknowledged by pulling SDA low during the ninth clock.
- R2: A non-matching address is not acknowledged. Every later byte up to the next start is neither acknowledged nor stored.
- R3: In a write, the first data byte is loaded into `ctrl1_o` and the second into `ctrl2_o`. Each data byte is acknowledged.
- R4: Data bytes after the second in the same write are acknowledged but change neither control word.
- R5: After reset both control words are 0, SDA is released, and the power-up flag is set.
- R6: The status byte is {flag, S1open, S1sel, S2open, S2sel, 3'b000}. Strap code 2'b00 (grounded) gives open/sel = 01. Code 2'b10 (left open) gives 10. Codes 2'b01 (mid level) and 2'b11 give 00.
- R7: The flag reads 1 in the first status read after reset and 0 in every later read.
- R8: A stop or repeated start inside a byte aborts the transfer. The partial byte is discarded and bytes already stored keep their values. A new frame after the repeated start is served normally.
- R9: When the master answers the status byte with a not-acknowledge, SDA stays released until the next start.
- R10: `sda_oe_o` never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high power-up reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (bus value) |
| addr_sel_i | input | 1 | Address strap, forms the address LSB |
| strap1_i | input | 2 | Pre-classified level of strap 1 (00 low, 01 mid, 10 open) |
| strap2_i | input | 2 | Pre-classified level of strap 2 (00 low, 01 mid, 10 open) |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| ctrl1_o | output | 8 | Control word for output one |
| ctrl2_o | output | 8 | Control word for output two |

## Verification
A wrong bit counter or a stuck state shows up within one byte. It appears either as a missing or misplaced acknowledge in the ninth clock or as a control word that differs from the byte just sent. The bench reads both control words after every write frame. A bad address compare appears in the first frame, because the address sweep covers every 7-bit value for both strap settings. A flag that clears at the wrong time, or a wrong strap field, shows up in the very next status read. The bench performs sixteen such reads, one for each strap combination.

// File: rtl/avsel_i2c_pkg.sv
package avsel_i2c_pkg;

  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_MID  = 2'b01,
    STRAP_HIGH = 2'b10
  } strap_lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } link_state_e;

  // {open, sel} pair reported for one three-level strap
  function automatic logic [1:0] strap_pair(input logic [1:0] code);
    case (code)
      STRAP_LOW:  strap_pair = 2'b01;
      STRAP_HIGH: strap_pair = 2'b10;
      default:    strap_pair = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/avsel_bus_edge.sv
module avsel_bus_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    start_det = scl_i & scl_q & sda_q & ~sda_i;
    stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/avsel_link_fsm.sv
module avsel_link_fsm
  import avsel_i2c_pkg::*;
#(
  parameter int DATA_W            = 8,
  parameter int ADDR_W            = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h48,
  parameter int NUM_CTRL          = 2,
  localparam int SEL_W            = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
  localparam int CNT_W            = $clog2(DATA_W + 1),
  localparam int WC_W             = $clog2(NUM_CTRL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-1:0] status_byte,
  output logic              wr_stb,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_start,
  output logic              sda_oe
);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
  localparam logic [WC_W-1:0]  WC_LAST  = WC_W'(NUM_CTRL);

  link_state_e         state;
  logic [CNT_W-1:0]    bitcnt;
  logic [DATA_W-1:0]   sh;
  logic                rw_q;
  logic                mack_q;
  logic [WC_W-1:0]     wcnt;
  logic [ADDR_W-1:0]   my_addr;

  assign my_addr = {BASE_ADDR[ADDR_W-1:1], addr_sel_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      wcnt     <= '0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_sel   <= '0;
      wr_data  <= '0;
      rd_start <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      rd_start <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        wcnt   <= '0;
        rw_q   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && bitcnt != BYTE_END) begin
              sh     <= {sh[DATA_W-2:0], sda_i};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BYTE_END) begin
              if (state == ST_ADDR) begin
                if (sh[DATA_W-1:1] == my_addr) begin
                  rw_q   <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end else begin
                  state  <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (wcnt != WC_LAST) begin
                  wr_stb  <= 1'b1;
                  wr_sel  <= SEL_W'(wcnt);
                  wr_data <= sh;
                  wcnt    <= wcnt + 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                state    <= ST_RDATA;
                sh       <= status_byte;
                sda_oe   <= ~status_byte[DATA_W-1];
                rd_start <= 1'b1;
              end else begin
                state  <= ST_WDATA;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == BYTE_END) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sh     <= {sh[DATA_W-2:0], 1'b0};
                sda_oe <= ~sh[DATA_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                bitcnt   <= '0;
                state    <= ST_RDATA;
                sh       <= status_byte;
                sda_oe   <= ~status_byte[DATA_W-1];
                rd_start <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/avsel_ctrl_bank.sv
module avsel_ctrl_bank
  import avsel_i2c_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_CTRL = 2,
  localparam int SEL_W   = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_stb,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           rd_start,
  input  logic [1:0]                     strap1_i,
  input  logic [1:0]                     strap2_i,
  output logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0]              status_byte
);
  logic por_flag;

  for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        ctrl_q[gi] <= '0;
      else if (wr_stb && wr_sel == SEL_W'(gi))
        ctrl_q[gi] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      por_flag <= 1'b1;
    else if (rd_start)
      por_flag <= 1'b0;
  end

  assign status_byte = {por_flag, strap_pair(strap1_i), strap_pair(strap2_i),
                        {(DATA_W-5){1'b0}}};
endmodule

// File: rtl/avsel_i2c_slave.sv
module avsel_i2c_slave
  import avsel_i2c_pkg::*;
#(
  parameter int DATA_W                    = 8,
  parameter int ADDR_W                    = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 7'h48,
  localparam int NUM_CTRL                 = 2,
  localparam int SEL_W                    = $clog2(NUM_CTRL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic [1:0]        strap1_i,
  input  logic [1:0]        strap2_i,
  output logic              sda_oe_o,
  output logic [DATA_W-1:0] ctrl1_o,
  output logic [DATA_W-1:0] ctrl2_o
);
  logic scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb, rd_start;
  logic [SEL_W-1:0] wr_sel;
  logic [DATA_W-1:0] wr_data, status_byte;
  logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl_q;

  avsel_bus_edge u_edge (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  avsel_link_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CTRL(NUM_CTRL)
  ) u_fsm (
    .clk(clk), .rst(rst), .sda_i(sda_i), .addr_sel_i(addr_sel_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .status_byte(status_byte),
    .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_start(rd_start), .sda_oe(sda_oe_o)
  );

  avsel_ctrl_bank #(
    .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_start(rd_start), .strap1_i(strap1_i), .strap2_i(strap2_i),
    .ctrl_q(ctrl_q), .status_byte(status_byte)
  );

  assign ctrl1_o = ctrl_q[0];
  assign ctrl2_o = ctrl_q[1];
endmodule

// File: rtl/avsel_i2c_chk.sv
module avsel_i2c_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [DATA_W-1:0] ctrl1_o,
  input logic [DATA_W-1:0] ctrl2_o
);
  // R10
  oe_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  // R1
  ack_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_i);

  // R3
  ctrl1_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl1_o) |-> !scl_i);

  // R3
  ctrl2_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl2_o) |-> !scl_i);

  // R5
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl1_o == '0 && ctrl2_o == '0 && !sda_oe_o));
endmodule

bind avsel_i2c_slave avsel_i2c_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .ctrl1_o(ctrl1_o), .ctrl2_o(ctrl2_o)
);

// File: tb/tb_avsel_i2c_slave.sv
module tb_avsel_i2c_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [1:0] strap1 = 2'b00, strap2 = 2'b00;
  logic sda_oe, sda_bus;
  logic [7:0] ctrl1, ctrl2;
  int checks = 0, errors = 0, oe_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  avsel_i2c_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .addr_sel_i(addr_sel),
    .strap1_i(strap1), .strap2_i(strap2), .sda_oe_o(sda_oe),
    .ctrl1_o(ctrl1), .ctrl2_o(ctrl2)
  );

  // SDA enable must not move while SCL is high (R10)
  logic prev_oe, prev_scl;
  always @(negedge clk) begin
    if (!rst && scl_m && prev_scl && sda_oe != prev_oe) oe_bad++;
    prev_oe  <= sda_oe;
    prev_scl <= scl_m;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; waitc(H); scl_m = 1; waitc(H); sda_m = 0; waitc(H); scl_m = 0; waitc(H);
  endtask

  task automatic bus_stop();
    sda_m = 0; waitc(H); scl_m = 1; waitc(H); sda_m = 1; waitc(H);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; waitc(H); scl_m = 1; waitc(H/2); s = sda_bus; waitc(H/2); scl_m = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      b = {b[6:0], s};
    end
    clk_bit(nack, s);
    sda_m = 1;
  endtask

  function automatic logic [1:0] pair(input logic [1:0] c);
    return (c == 2'b00) ? 2'b01 : (c == 2'b10) ? 2'b10 : 2'b00;
  endfunction

  task automatic read_status(input logic [7:0] exp, input string req);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte({7'h48 | {6'd0, addr_sel}, 1'b1}, a);
    chk("R1 read addr ack", a, 1);
    read_byte(1'b1, b);
    chk(req, b, exp);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, s;
    logic [7:0] b;
    logic [7:0] e1, e2;
    waitc(5); rst = 0; waitc(2);
    // R5 reset state
    chk("R5 ctrl1 reset", ctrl1, 0);
    chk("R5 ctrl2 reset", ctrl2, 0);
    chk("R5 sda released", sda_oe, 0);

    // R7 first read shows the flag, R6 layout with both straps grounded
    read_status({1'b1, pair(2'b00), pair(2'b00), 3'b000}, "R7 first read flag");
    read_status({1'b0, pair(2'b00), pair(2'b00), 3'b000}, "R7 flag cleared");

    // R1/R2 address sweep, both strap settings, write direction
    for (int sel = 0; sel < 2; sel++) begin
      addr_sel = sel[0];
      for (int ad = 0; ad < 128; ad++) begin
        bus_start();
        send_byte({ad[6:0], 1'b0}, a);
        bus_stop();
        chk(((ad == (72 | sel)) ? "R1 match ack" : "R2 mismatch nak"), a,
            (ad == (72 | sel)) ? 1 : 0);
      end
    end
    chk("R2 sweep ctrl1 untouched", ctrl1, 0);
    chk("R2 sweep ctrl2 untouched", ctrl2, 0);

    // R3 write patterns
    addr_sel = 1'b0;
    for (int p = 0; p < 6; p++) begin
      e1 = 8'(p * 37 + 5);
      e2 = ~8'(p * 91 + 3);
      bus_start();
      send_byte(8'h90, a);
      send_byte(e1, a); chk("R3 byte1 ack", a, 1);
      send_byte(e2, a); chk("R3 byte2 ack", a, 1);
      bus_stop();
      chk("R3 ctrl1", ctrl1, e1);
      chk("R3 ctrl2", ctrl2, e2);
    end

    // R4 surplus bytes
    bus_start();
    send_byte(8'h90, a);
    send_byte(8'hA5, a);
    send_byte(8'h5A, a);
    send_byte(8'hFF, a); chk("R4 third byte ack", a, 1);
    send_byte(8'h00, a); chk("R4 fourth byte ack", a, 1);
    bus_stop();
    chk("R4 ctrl1 kept", ctrl1, 8'hA5);
    chk("R4 ctrl2 kept", ctrl2, 8'h5A);

    // R2 wrong address followed by data
    bus_start();
    send_byte(8'h92, a); chk("R2 wrong addr nak", a, 0);
    send_byte(8'hEE, a); chk("R2 data after mismatch nak", a, 0);
    send_byte(8'h11, a);
    bus_stop();
    chk("R2 ctrl1 unchanged", ctrl1, 8'hA5);
    chk("R2 ctrl2 unchanged", ctrl2, 8'h5A);
    bus_start();
    send_byte(8'h93, a); chk("R2 wrong read addr nak", a, 0);
    bus_stop();

    // R1 high address strap write
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'h92, a); chk("R1 strap high ack", a, 1);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    bus_stop();
    chk("R1 ctrl1 via 92", ctrl1, 8'h11);
    chk("R1 ctrl2 via 92", ctrl2, 8'h22);

    // R8 stop inside first data byte
    bus_start();
    send_byte(8'h92, a);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_stop();
    chk("R8 stop abort ctrl1", ctrl1, 8'h11);
    chk("R8 stop abort ctrl2", ctrl2, 8'h22);

    // R8 repeated start inside second byte, then a fresh frame
    bus_start();
    send_byte(8'h92, a);
    send_byte(8'h33, a);
    for (int i = 0; i < 5; i++) clk_bit(1'b1, s);
    chk("R8 first byte kept", ctrl1, 8'h33);
    chk("R8 partial discarded", ctrl2, 8'h22);
    bus_start();
    send_byte(8'h92, a); chk("R8 restart ack", a, 1);
    send_byte(8'h44, a);
    send_byte(8'h55, a);
    bus_stop();
    chk("R8 restart ctrl1", ctrl1, 8'h44);
    chk("R8 restart ctrl2", ctrl2, 8'h55);

    // R6 strap sweep
    for (int c1 = 0; c1 < 4; c1++) begin
      for (int c2 = 0; c2 < 4; c2++) begin
        strap1 = c1[1:0];
        strap2 = c2[1:0];
        read_status({1'b0, pair(c1[1:0]), pair(c2[1:0]), 3'b000}, "R6 status");
      end
    end

    // R9 released after NACK
    bus_start();
    send_byte(8'h93, a);
    read_byte(1'b1, b);
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      chk("R9 sda released", s, 1);
    end
    bus_stop();

    chk("R10 oe moves only with SCL low", oe_bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule